// File: doc/BRIEF.md
# Adaptive Feedforward Equalizer with LMS Coefficient Update

This block takes one signed fixed-point sample per unit interval and forms a weighted sum over a tapped delay line. The output therefore depends on samples both after and before the cursor position, so intersymbol interference from both sides of the main pulse can be cancelled. Each coefficient corrects itself once per accepted sample with the least-mean-square rule. The error is a reference level minus the equalizer output, and each coefficient moves by that error times the sample at its tap, scaled down by a programmable right shift.

A per-sample select picks the reference. In training mode it is a known bit stream that arrives next to the samples and is delayed by a programmable number of samples so that it lines up with the cursor. In blind mode it is the sign decision that a binary slicer makes on the equalizer output. All control inputs are captured with the sample they accompany. The control inputs are the reference select, the adaptation enable, the step shift and the training delay. A coefficient update takes place in the same clock edge that registers the output for that sample.

Top module: `adaptive_ffe`

## Requirements
- R1: After reset `y_out` is 0 and `y_valid` is 0. The cursor coefficient (tap index 2 by default) is 256, which is unity with 8 fraction bits. Every other coefficient is 0.
- R2: A sample captured with `valid_in` at clock edge k produces a result at edge k+1, and `y_valid` is high between edges k+1 and k+2. Tap 0 holds the newest sample and tap i holds the sample accepted i samples earlier. The result is `y = floor(sum(c_i * x_i) / 256)`.
- R3: `y_out` saturates to the range -512..511 (10-bit two's complement) and does not wrap.
- R4: Whenever `y_valid` is high, `bit_out` is 1 if `y_out` >= 0 and 0 otherwise.
- R5: In training mode (`blind_mode`=0) the reference is +64 if the training bit given with the sample D samples before the current one is 1, and -64 if it is 0. D is `train_dly`, and D=0 selects the current sample's bit. The error is e = reference - y. With `adapt_en`=1 each coefficient becomes `c_i + floor(e*x_i / 2^mu_shift)`.
- R6: In blind mode (`blind_mode`=1) the reference is +64 when y >= 0 and -64 otherwise. The update rule is otherwise the same as R5.
- R7: Coefficients saturate to the range -2048..2047 (12-bit two's complement) and do not wrap.
- R8: A sample captured with `adapt_en`=0 leaves every coefficient unchanged. In cycles without an accepted sample, the coefficients also stay unchanged.
- R9: While no result is due, `y_valid` is 0 and `y_out` and `bit_out` keep their last values.
- R10: Samples may arrive on consecutive cycles. Each update then uses the taps of the sample it belongs to, even though the next sample is shifting in at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_in | input | 1 | Qualifies `x_in` and the per-sample controls |
| x_in | input | 8 | Signed input sample |
| train_bit | input | 1 | Training symbol that goes with this sample |
| blind_mode | input | 1 | 1 selects the slicer reference, 0 selects the training reference |
| adapt_en | input | 1 | 1 lets this sample update the coefficients |
| mu_shift | input | 4 | Step size as a right shift of the gradient |
| train_dly | input | 3 | Training delay in samples |
| y_out | output | 10 | Signed equalized sample |
| y_valid | output | 1 | `y_out` and `bit_out` are new this cycle |
| bit_out | output | 1 | Slicer decision of `y_out` |
| coef_out | output | 60 | Coefficients; tap i is bits [12*i+11 : 12*i] |

## Verification
A coefficient update and a fresh sample shifting into the delay line can fall on the same clock edge whenever samples arrive back to back. If the update used the shifted taps, the coefficients would drift from the LMS rule. The training scenario streams samples on every cycle with a nonzero training delay and adaptation enabled. A bench model that applies the rule one sample at a time predicts every coefficient, and the bench compares the coefficient bus with that prediction two edges after each sample. Gapped traffic in the blind and frozen scenarios checks the same update logic when the two events fall on separate edges.

// File: rtl/ffe_pkg.sv
package ffe_pkg;

    // Source of the reference level used to form the error
    typedef enum logic {
        REF_TRAIN = 1'b0,
        REF_SLICE = 1'b1
    } ref_src_e;

endpackage

// File: rtl/ffe_tap_line.sv
module ffe_tap_line #(
    parameter int NTAPS  = 5,
    parameter int DW     = 8,
    parameter int TDEPTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push,
    input  logic [DW-1:0]         x_in,
    input  logic                  t_in,
    output logic [NTAPS*DW-1:0]   taps_flat,
    output logic [TDEPTH-1:0]     tbits
);

    typedef struct packed {
        logic [NTAPS-1:0][DW-1:0] tap;
        logic [TDEPTH-1:0]        tb;
    } line_t;

    line_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.tap[0] = x_in;
            for (int i = 1; i < NTAPS; i++) begin
                st_d.tap[i] = st_q.tap[i-1];
            end
            st_d.tb = {st_q.tb[TDEPTH-2:0], t_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign taps_flat = st_q.tap;
    assign tbits     = st_q.tb;

    // Newest sample enters tap 0, older ones move one place (R2, R10)
    p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (st_q.tap[0] == $past(x_in)) && (st_q.tap[1] == $past(st_q.tap[0]))
                 && (st_q.tb[0] == $past(t_in)));

    // Without a sample nothing moves (R10)
    p_line_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !push |=> $stable(st_q));

endmodule

// File: rtl/ffe_mac.sv
module ffe_mac #(
    parameter int NTAPS = 5,
    parameter int DW    = 8,
    parameter int CW    = 12,
    parameter int CF    = 8,
    parameter int OW    = 10
) (
    input  logic [NTAPS*DW-1:0]   taps_flat,
    input  logic [NTAPS*CW-1:0]   coef_flat,
    output logic signed [OW-1:0]  y
);

    localparam int PW = DW + CW;
    localparam int AW = PW + $clog2(NTAPS) + 1;
    localparam logic signed [AW-1:0] YMAX = AW'((2 ** (OW - 1)) - 1);
    localparam logic signed [AW-1:0] YMIN = AW'(-(2 ** (OW - 1)));

    logic signed [PW-1:0] prod [NTAPS];
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] scaled;
    logic signed [AW-1:0] clipped;

    for (genvar g = 0; g < NTAPS; g++) begin : g_prod
        assign prod[g] = $signed(taps_flat[g*DW +: DW]) * $signed(coef_flat[g*CW +: CW]);
    end

    always_comb begin
        acc = '0;
        for (int i = 0; i < NTAPS; i++) begin
            acc = acc + AW'(prod[i]);
        end
        scaled = acc >>> CF;
        if (scaled > YMAX) begin
            clipped = YMAX;
        end else if (scaled < YMIN) begin
            clipped = YMIN;
        end else begin
            clipped = scaled;
        end
        y = OW'(clipped);
    end

endmodule

// File: rtl/ffe_coef_bank.sv
module ffe_coef_bank #(
    parameter int NTAPS  = 5,
    parameter int DW     = 8,
    parameter int CW     = 12,
    parameter int CF     = 8,
    parameter int OW     = 10,
    parameter int CURSOR = 2,
    parameter int SHW    = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  upd,
    input  logic signed [OW:0]    err,
    input  logic [SHW-1:0]        mu,
    input  logic [NTAPS*DW-1:0]   taps_flat,
    output logic [NTAPS*CW-1:0]   coef_flat
);

    localparam int EPW = OW + 1 + DW;
    localparam int SW  = ((CW > EPW) ? CW : EPW) + 1;
    localparam logic signed [SW-1:0] CMAX = SW'((2 ** (CW - 1)) - 1);
    localparam logic signed [SW-1:0] CMIN = SW'(-(2 ** (CW - 1)));
    localparam logic [CW-1:0] UNITY = CW'(1 << CF);

    typedef struct packed {
        logic [NTAPS-1:0][CW-1:0] c;
    } bank_t;

    bank_t st_d, st_q;
    logic signed [EPW-1:0] grad [NTAPS];

    for (genvar g = 0; g < NTAPS; g++) begin : g_grad
        logic signed [EPW-1:0] raw;
        assign raw     = EPW'(err) * EPW'($signed(taps_flat[g*DW +: DW]));
        assign grad[g] = raw >>> mu;
    end

    always_comb begin
        logic signed [SW-1:0] sum;
        st_d = st_q;
        sum  = '0;
        if (upd) begin
            for (int i = 0; i < NTAPS; i++) begin
                sum = SW'($signed(st_q.c[i])) + SW'(grad[i]);
                if (sum > CMAX) begin
                    st_d.c[i] = CW'(CMAX);
                end else if (sum < CMIN) begin
                    st_d.c[i] = CW'(CMIN);
                end else begin
                    st_d.c[i] = CW'(sum);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.c[CURSOR] <= UNITY;
        end else begin
            st_q <= st_d;
        end
    end

    assign coef_flat = st_q.c;

    // Frozen when no enabled sample is being applied (R8)
    p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(st_q.c));

    // A zero error leaves every weight where it was (R5)
    p_zero_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && (err == '0)) |=> $stable(st_q.c));

endmodule

// File: rtl/adaptive_ffe.sv
module adaptive_ffe #(
    parameter int NTAPS  = 5,
    parameter int CURSOR = 2,
    parameter int DW     = 8,
    parameter int CW     = 12,
    parameter int CF     = 8,
    parameter int TDEPTH = 8,
    parameter int SHW    = 4,
    localparam int OW    = DW + 2,
    localparam int TDW   = $clog2(TDEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  valid_in,
    input  logic [DW-1:0]         x_in,
    input  logic                  train_bit,
    input  logic                  blind_mode,
    input  logic                  adapt_en,
    input  logic [SHW-1:0]        mu_shift,
    input  logic [TDW-1:0]        train_dly,
    output logic [OW-1:0]         y_out,
    output logic                  y_valid,
    output logic                  bit_out,
    output logic [NTAPS*CW-1:0]   coef_out
);
    import ffe_pkg::*;

    localparam int EW  = OW + 1;
    localparam int ONE = 2 ** (DW - 2);
    localparam logic signed [EW-1:0] LVL_POS = EW'(ONE);
    localparam logic signed [EW-1:0] LVL_NEG = EW'(-ONE);

    typedef struct packed {
        logic            sv;
        ref_src_e        src;
        logic            adapt;
        logic [SHW-1:0]  mu;
        logic [TDW-1:0]  dly;
        logic [OW-1:0]   y;
        logic            yv;
        logic            dec;
    } top_t;

    top_t st_d, st_q;

    logic [NTAPS*DW-1:0]  taps_flat;
    logic [TDEPTH-1:0]    tbits;
    logic signed [OW-1:0] y_now;
    logic signed [EW-1:0] ref_lvl;
    logic signed [EW-1:0] err;
    logic                 upd;

    ffe_tap_line #(
        .NTAPS  (NTAPS),
        .DW     (DW),
        .TDEPTH (TDEPTH)
    ) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (valid_in),
        .x_in      (x_in),
        .t_in      (train_bit),
        .taps_flat (taps_flat),
        .tbits     (tbits)
    );

    ffe_mac #(
        .NTAPS (NTAPS),
        .DW    (DW),
        .CW    (CW),
        .CF    (CF),
        .OW    (OW)
    ) u_mac (
        .taps_flat (taps_flat),
        .coef_flat (coef_out),
        .y         (y_now)
    );

    assign upd = st_q.sv && st_q.adapt;

    ffe_coef_bank #(
        .NTAPS  (NTAPS),
        .DW     (DW),
        .CW     (CW),
        .CF     (CF),
        .OW     (OW),
        .CURSOR (CURSOR),
        .SHW    (SHW)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (upd),
        .err       (err),
        .mu        (st_q.mu),
        .taps_flat (taps_flat),
        .coef_flat (coef_out)
    );

    // Reference level and error for the sample held in the capture stage
    always_comb begin
        if (st_q.src == REF_SLICE) begin
            ref_lvl = (y_now >= 0) ? LVL_POS : LVL_NEG;
        end else begin
            ref_lvl = tbits[st_q.dly] ? LVL_POS : LVL_NEG;
        end
        err = ref_lvl - EW'(y_now);
    end

    always_comb begin
        st_d    = st_q;
        st_d.sv = valid_in;
        if (valid_in) begin
            st_d.src   = ref_src_e'(blind_mode);
            st_d.adapt = adapt_en;
            st_d.mu    = mu_shift;
            st_d.dly   = train_dly;
        end
        st_d.yv = st_q.sv;
        if (st_q.sv) begin
            st_d.y   = y_now;
            st_d.dec = (y_now >= 0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign y_out   = st_q.y;
    assign y_valid = st_q.yv;
    assign bit_out = st_q.dec;

    // A captured sample always yields a result one edge later (R2)
    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sv |=> y_valid);

    // No result due: outputs keep their values (R9)
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.sv |=> (!y_valid && $stable(y_out) && $stable(bit_out)));

    // Decision agrees with the sign of the registered sample (R4)
    p_decision_r4: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |-> (bit_out == !y_out[OW-1]));

    // Blind reference never has the opposite sign of the output (R6)
    p_blind_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sv && (st_q.src == REF_SLICE)) |-> (ref_lvl[EW-1] == y_now[OW-1]));

endmodule

// File: tb/test_adaptive_ffe.sv
`timescale 1ns/1ps
module test_adaptive_ffe;

    localparam int NT = 5;
    localparam int CW = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [7:0]  x_in = '0;
    logic        train_bit = 1'b0;
    logic        blind_mode = 1'b0;
    logic        adapt_en = 1'b0;
    logic [3:0]  mu_shift = '0;
    logic [2:0]  train_dly = '0;
    logic [9:0]  y_out;
    logic        y_valid;
    logic        bit_out;
    logic [NT*CW-1:0] coef_out;

    adaptive_ffe i_adaptive_ffe (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_in   (valid_in),
        .x_in       (x_in),
        .train_bit  (train_bit),
        .blind_mode (blind_mode),
        .adapt_en   (adapt_en),
        .mu_shift   (mu_shift),
        .train_dly  (train_dly),
        .y_out      (y_out),
        .y_valid    (y_valid),
        .bit_out    (bit_out),
        .coef_out   (coef_out)
    );

    always #2 clk = ~clk;

    int errors = 0;
    int checks = 0;

    // Bench model state
    int xm [NT];
    int am [NT];
    int th [8];
    bit    pv [2];
    int    py [2];
    int    pa [2][NT];
    string ptag [2];
    int    last_y;
    int    lfsr = 32'h1ACE;

    function automatic int sat(int v, int lo, int hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic int coef_at(int i);
        return int'($signed(coef_out[i*CW +: CW]));
    endfunction

    task automatic next_rand(output int r);
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
        r = lfsr;
    endtask

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NT; i++) begin
            xm[i] = 0;
            am[i] = (i == 2) ? 256 : 0;
        end
        for (int i = 0; i < 8; i++) th[i] = 0;
        for (int k = 0; k < 2; k++) begin
            pv[k] = 1'b0;
            py[k] = 0;
            ptag[k] = "R1";
            for (int i = 0; i < NT; i++) pa[k][i] = am[i];
        end
        last_y = 0;
    endtask

    // Called at a falling edge: check the entry driven two steps ago, then drive
    task automatic step(bit v, int x, bit t, bit bl, bit ad, int mu, int dl, string tag);
        int acc, y, rf, e;
        chk({ptag[1], " y_valid"}, int'(y_valid), int'(pv[1]));
        if (pv[1]) begin
            chk({ptag[1], " y_out"}, int'($signed(y_out)), py[1]);
            chk("R4 bit_out", int'(bit_out), (py[1] >= 0) ? 1 : 0);
            last_y = py[1];
        end else begin
            chk("R9 y_out held", int'($signed(y_out)), last_y);
        end
        for (int i = 0; i < NT; i++) begin
            chk({ptag[1], " coef"}, coef_at(i), pa[1][i]);
        end
        pv[1] = pv[0];
        py[1] = py[0];
        ptag[1] = ptag[0];
        for (int i = 0; i < NT; i++) pa[1][i] = pa[0][i];

        valid_in   = v;
        x_in       = 8'(x);
        train_bit  = t;
        blind_mode = bl;
        adapt_en   = ad;
        mu_shift   = 4'(mu);
        train_dly  = 3'(dl);
        y = py[0];
        if (v) begin
            for (int i = NT - 1; i > 0; i--) xm[i] = xm[i-1];
            xm[0] = x;
            for (int i = 7; i > 0; i--) th[i] = th[i-1];
            th[0] = int'(t);
            acc = 0;
            for (int i = 0; i < NT; i++) acc += am[i] * xm[i];
            y = sat(acc >>> 8, -512, 511);
            if (bl) rf = (y >= 0) ? 64 : -64;
            else    rf = th[dl] ? 64 : -64;
            e = rf - y;
            if (ad) begin
                for (int i = 0; i < NT; i++) begin
                    am[i] = sat(am[i] + ((e * xm[i]) >>> mu), -2048, 2047);
                end
            end
        end
        pv[0] = v;
        py[0] = y;
        ptag[0] = tag;
        for (int i = 0; i < NT; i++) pa[0][i] = am[i];
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drain(string tag);
        step(1'b0, 0, 1'b0, 1'b0, 1'b0, 0, 0, tag);
        step(1'b0, 0, 1'b0, 1'b0, 1'b0, 0, 0, tag);
        step(1'b0, 0, 1'b0, 1'b0, 1'b0, 0, 0, tag);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        chk("R1 y_valid", int'(y_valid), 0);
        chk("R1 y_out", int'($signed(y_out)), 0);
        for (int i = 0; i < NT; i++) chk("R1 coef", coef_at(i), (i == 2) ? 256 : 0);
    endtask

    // Unity cursor and no adaptation: output equals input two samples back
    task automatic t_fixed();
        int xs [8] = '{127, -128, 5, -1, 0, 64, -64, 33};
        for (int k = 0; k < 8; k++) step(1'b1, xs[k], 1'b0, 1'b0, 1'b0, 4, 0, "R2 R8");
        drain("R2 R8");
    endtask

    // Training with a two-sample reference delay, samples on every cycle
    task automatic t_training();
        int s0 = 1, s1 = 1, r;
        for (int k = 0; k < 40; k++) begin
            next_rand(r);
            s1 = s0;
            s0 = (r & 1) ? 1 : -1;
            step(1'b1, 48 * s0 + 16 * s1, s0 > 0, 1'b0, 1'b1, 9, 2, "R5 R10");
        end
        drain("R5 R10");
    endtask

    // Blind running with gaps between samples
    task automatic t_blind();
        int r;
        for (int k = 0; k < 24; k++) begin
            next_rand(r);
            step(1'b1, sat(((r & 1) ? 40 : -40) + ((r >> 3) & 15) - 8, -128, 127),
                 1'b0, 1'b1, 1'b1, 10, 0, "R6");
            if (k % 3 == 0) step(1'b0, 0, 1'b0, 1'b1, 1'b1, 10, 0, "R6 R9");
        end
        drain("R6");
    endtask

    // Adaptation disabled, gapped traffic: weights fixed, outputs held in gaps
    task automatic t_frozen();
        int r;
        for (int k = 0; k < 16; k++) begin
            next_rand(r);
            step(1'b1, sat((r & 255) - 128, -128, 127), r[4], 1'b0, 1'b0, 0, 1, "R8");
            step(1'b0, 0, 1'b0, 1'b0, 1'b1, 0, 0, "R8 R9");
        end
        drain("R8 R9");
    endtask

    // Huge step drives weights and output into their limits
    task automatic t_saturate();
        for (int k = 0; k < 10; k++) step(1'b1, 127, 1'b1, 1'b0, 1'b1, 0, 0, "R3 R7");
        drain("R3 R7");
        chk("R7 cursor at a limit", int'(coef_at(2) == 2047 || coef_at(2) == -2048), 1);
        chk("R3 output at a limit",
            int'($signed(y_out) == 511 || $signed(y_out) == -512), 1);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_fixed();
        t_training();
        t_blind();
        t_frozen();
        t_saturate();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule